// File: doc/BRIEF.md
# Power-Budgeted Self-Test Session Sequencer

This block runs a fixed set of six built-in self-tests as a series of sessions. A session switches on a group of tests together. Each test's enable stays high for that test's own length in cycles. The session is over when its longest member finishes, and the next session begins on the following cycle. Session membership comes from a small table of test masks plus a session count. Both can be rewritten while the sequencer is idle. Test lengths and power weights are parameters.

Before a session is launched, the sequencer adds up the power weights of the tests it is about to enable. If the sum is above the power budget, it raises an error and stops without enabling anything. Each test also reports completion on its own done input. If a test's window closes without that report, the run is aborted with the same error flag. A completed run ends with a one-cycle done pulse. An elapsed counter then holds the total number of cycles during which any test was enabled.

The default table holds three sessions: {T3,T4}, then {T2,T5}, then {T1,T6}. With lengths of 100, 10, 10, 5, 10 and 100 cycles for T1 to T6, this schedule takes 120 cycles. The weights are 2, 1, 1, 1, 2 and 1, and the budget is 4.

Top module: `bist_session_seq`

## Requirements
- R1: After reset, all test enables, busy, done and error are low, and the elapsed counter is 0.
- R2: A start pulse while idle, with a non-zero session count, raises the enables of session 0 and busy on the cycle after start is sampled. Mask bit i selects test T(i+1).
- R3: Each enabled test's enable is high for exactly that test's length in consecutive cycles, then drops, even while other tests in the session continue.
- R4: The next session's enables rise on the cycle right after the last enable of the current session was high, with no idle cycle between them.
- R5: Before each launch, the weights of the masked tests are summed. A sum above the limit (4) sets error, enables no test and returns to idle. A sum equal to the limit is accepted. The summed weight of the high enables never exceeds the limit.
- R6: After the last session, done is high for exactly one cycle, on the cycle after the final enable drops, and busy is low in that cycle.
- R7: The elapsed counter clears on an accepted start and increments in every cycle that has any enable high. With the default schedule it reads 120 at done.
- R8: If a test's enable window ends without its done input having been high during the window, error rises on the next cycle, all enables drop, busy falls and no done pulse follows.
- R9: Table entry and count writes take effect only while idle. Writes and start pulses issued while busy are ignored. A count write above the table depth (8) is ignored.
- R10: A start with a session count of 0 produces a done pulse on the next cycle with elapsed 0 and no enable.
- R11: The error flag stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| tbl_we | input | 1 | Write one session mask entry |
| tbl_idx | input | 3 | Entry index for the write |
| tbl_mask | input | 6 | Test mask, bit i = test T(i+1) |
| cnt_we | input | 1 | Write the session count |
| cnt_val | input | 4 | New session count (0 to 8) |
| test_done | input | 6 | Per-test completion report |
| test_en | output | 6 | Per-test enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Power budget or missing completion error |
| elapsed | output | 16 | Cycles with any test enabled in the current or last run |

## Verification
A wrong per-test counter shows at the ports as an enable window of the wrong length. It also shifts the next session's first enable, so the fault is visible within one test length. A wrong session index or power sum either enables the wrong mask on the first cycle of a session or raises error where none is due. A corrupted elapsed count or state bit appears at the latest at the done pulse, where the elapsed value and the pulse timing are compared with the sum of the session durations.

// File: rtl/bist_sched_pkg.sv
package bist_sched_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/bist_sched_table.sv
module bist_sched_table #(
  parameter int NT    = 6,
  parameter int DEPTH = 8,
  parameter int IW    = 3,
  parameter int CW    = 4,
  parameter logic [DEPTH*NT-1:0] DEF_MASKS = '0,
  parameter logic [CW-1:0]       DEF_CNT   = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [NT-1:0] wr_mask,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_in,
  input  logic [IW-1:0] rd_idx,
  output logic [NT-1:0] rd_mask,
  output logic [CW-1:0] count
);
  logic [NT-1:0] masks [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        masks[e] <= DEF_MASKS[e*NT +: NT];
      else if (wr_en && !lock && (wr_idx == IW'(e)))
        masks[e] <= wr_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= DEF_CNT;
    else if (cnt_we && !lock && (int'(cnt_in) <= DEPTH))
      count <= cnt_in;
  end

  assign rd_mask = masks[rd_idx];

  // R9
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R9
  locked_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(count));
endmodule

// File: rtl/bist_test_timer.sv
module bist_test_timer #(
  parameter int LEN_W = 8,
  parameter logic [LEN_W-1:0] LEN = 8'd1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic abort,
  input  logic done_in,
  output logic en,
  output logic expire,
  output logic miss
);
  logic [LEN_W-1:0] remain;
  logic             seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en     <= 1'b0;
      remain <= '0;
      seen   <= 1'b0;
    end else if (load) begin
      en     <= 1'b1;
      remain <= LEN - 1'b1;
      seen   <= 1'b0;
    end else if (abort) begin
      en <= 1'b0;
    end else if (en) begin
      if (done_in) seen <= 1'b1;
      if (remain == '0) en <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end

  assign expire = en && (remain == '0);
  assign miss   = expire && !seen && !done_in;

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !expire && !abort) |=> en);

  // R3
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !en);
endmodule

// File: rtl/bist_session_seq.sv
module bist_session_seq #(
  parameter int NUM_TESTS = 6,
  parameter int MAX_SESS  = 8,
  parameter int LEN_W     = 8,
  parameter int PWR_W     = 4,
  parameter int ELAPSED_W = 16,
  parameter int PWR_LIMIT = 4,
  parameter logic [NUM_TESTS*LEN_W-1:0] TEST_LEN =
    {8'd100, 8'd10, 8'd5, 8'd10, 8'd10, 8'd100},
  parameter logic [NUM_TESTS*PWR_W-1:0] TEST_PWR =
    {4'd1, 4'd2, 4'd1, 4'd1, 4'd1, 4'd2},
  parameter logic [MAX_SESS*NUM_TESTS-1:0] DEF_MASKS =
    {30'd0, 6'b100001, 6'b010010, 6'b001100},
  parameter int DEF_COUNT = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic                                  tbl_we,
  input  logic [$clog2(MAX_SESS)-1:0]           tbl_idx,
  input  logic [NUM_TESTS-1:0]                  tbl_mask,
  input  logic                                  cnt_we,
  input  logic [$clog2(MAX_SESS+1)-1:0]         cnt_val,
  input  logic [NUM_TESTS-1:0]                  test_done,
  output logic [NUM_TESTS-1:0]                  test_en,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  err,
  output logic [ELAPSED_W-1:0]                  elapsed
);
  import bist_sched_pkg::*;

  localparam int IW    = $clog2(MAX_SESS);
  localparam int CW    = $clog2(MAX_SESS + 1);
  localparam int SUM_W = PWR_W + $clog2(NUM_TESTS + 1);

  function automatic logic [SUM_W-1:0] pwr_sum(input logic [NUM_TESTS-1:0] m);
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_TESTS; i++)
      if (m[i]) acc = acc + SUM_W'(TEST_PWR[i*PWR_W +: PWR_W]);
    return acc;
  endfunction

  seq_state_e           state;
  logic [IW-1:0]        sess_idx;
  logic [IW-1:0]        rd_idx;
  logic [NUM_TESTS-1:0] rd_mask;
  logic [CW-1:0]        sess_cnt;
  logic [NUM_TESTS-1:0] expire_v;
  logic [NUM_TESTS-1:0] miss_v;
  logic [NUM_TESTS-1:0] load_v;

  // named internal events
  logic idle_start;
  logic sess_end;
  logic last_sess;
  logic any_miss;
  logic over_budget;
  logic launch_req;
  logic launch;
  logic abort;
  logic finish;

  assign idle_start  = (state == SEQ_IDLE) && start;
  assign sess_end    = (state == SEQ_RUN) && ((test_en & ~expire_v) == '0);
  assign last_sess   = ((CW'(sess_idx) + 1'b1) == sess_cnt);
  assign any_miss    = (state == SEQ_RUN) && (|miss_v);
  assign rd_idx      = (state == SEQ_IDLE) ? '0 : sess_idx + 1'b1;
  assign over_budget = int'(pwr_sum(rd_mask)) > PWR_LIMIT;
  assign launch_req  = (idle_start && (sess_cnt != '0)) ||
                       (sess_end && !any_miss && !last_sess);
  assign launch      = launch_req && !over_budget;
  assign abort       = any_miss || (launch_req && over_budget);
  assign finish      = (idle_start && (sess_cnt == '0)) ||
                       (sess_end && !any_miss && last_sess);
  assign load_v      = launch ? rd_mask : '0;

  bist_sched_table #(
    .NT(NUM_TESTS), .DEPTH(MAX_SESS), .IW(IW), .CW(CW),
    .DEF_MASKS(DEF_MASKS), .DEF_CNT(CW'(DEF_COUNT))
  ) u_table (
    .clk(clk), .rst_n(rst_n), .lock(state == SEQ_RUN),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_mask(tbl_mask),
    .cnt_we(cnt_we), .cnt_in(cnt_val),
    .rd_idx(rd_idx), .rd_mask(rd_mask), .count(sess_cnt)
  );

  for (genvar t = 0; t < NUM_TESTS; t++) begin : g_test
    bist_test_timer #(
      .LEN_W(LEN_W), .LEN(TEST_LEN[t*LEN_W +: LEN_W])
    ) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load_v[t]), .abort(abort),
      .done_in(test_done[t]), .en(test_en[t]),
      .expire(expire_v[t]), .miss(miss_v[t])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      sess_idx <= '0;
      err      <= 1'b0;
      done     <= 1'b0;
      elapsed  <= '0;
    end else begin
      done <= finish;
      if (launch) sess_idx <= rd_idx;
      if (launch)                    state <= SEQ_RUN;
      else if (abort || finish)      state <= SEQ_IDLE;
      if (idle_start)  err <= abort;
      else if (abort)  err <= 1'b1;
      if (idle_start)     elapsed <= '0;
      else if (|test_en)  elapsed <= elapsed + 1'b1;
    end
  end

  assign busy = (state == SEQ_RUN);

  // R5
  power_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pwr_sum(test_en)) <= PWR_LIMIT);

  // R2
  en_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|test_en) |-> busy);

  // R6
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (test_en == '0 && !busy));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (test_en == '0 || busy));

  // R7
  elapsed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (|test_en)) |=> (elapsed == $past(elapsed) + 1'b1));

  // R8
  miss_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_miss |=> (err && !busy && test_en == '0));
endmodule

// File: tb/bist_session_seq_bench.sv
module bist_session_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       tbl_we = 1'b0;
  logic [2:0] tbl_idx = '0;
  logic [5:0] tbl_mask = '0;
  logic       cnt_we = 1'b0;
  logic [3:0] cnt_val = '0;
  logic [5:0] done_allow = 6'b111111;
  logic [5:0] test_done;
  logic [5:0] test_en;
  logic       busy, done, err;
  logic [15:0] elapsed;

  assign test_done = test_en & done_allow;

  always #4 clk = ~clk;

  bist_session_seq u_bist_session_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_mask(tbl_mask),
    .cnt_we(cnt_we), .cnt_val(cnt_val), .test_done(test_done),
    .test_en(test_en), .busy(busy), .done(done), .err(err),
    .elapsed(elapsed)
  );

  int n_run = 0;
  int n_fail = 0;
  int t_len [6] = '{100, 10, 10, 5, 10, 100};
  int t_pwr [6] = '{2, 1, 1, 1, 2, 1};
  int hi_cnt [6];
  int first_hi [6];
  int rises [6];
  int done_at, err_at, max_pwr, busy0, busy_at_done, el_end;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_entry(input int idx, input logic [5:0] m);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_mask = m;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic write_count(input int c);
    @(negedge clk);
    cnt_we = 1'b1; cnt_val = 4'(c);
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // start a run and record per-test activity, sample s = s-th cycle after start edge
  task automatic run_sched(input int inject_at);
    logic [5:0] prev;
    for (int i = 0; i < 6; i++) begin hi_cnt[i] = 0; first_hi[i] = -1; rises[i] = 0; end
    done_at = -1; err_at = -1; max_pwr = 0; busy0 = 0; busy_at_done = 0; el_end = 0;
    prev = '0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < 1000; s++) begin
      int p;
      p = 0;
      if (s == 0) busy0 = busy;
      for (int i = 0; i < 6; i++) begin
        if (test_en[i]) begin
          hi_cnt[i]++;
          p += t_pwr[i];
          if (first_hi[i] < 0) first_hi[i] = s;
          if (!prev[i]) rises[i]++;
        end
      end
      if (p > max_pwr) max_pwr = p;
      prev = test_en;
      if (done && done_at < 0) begin done_at = s; busy_at_done = busy; end
      if (err && err_at < 0) err_at = s;
      if (done || (err && !busy)) begin el_end = elapsed; break; end
      if (s == inject_at) begin
        tbl_we = 1'b1; tbl_idx = 3'd1; tbl_mask = 6'b111111;
        cnt_we = 1'b1; cnt_val = 4'd1; start = 1'b1;
      end
      @(negedge clk);
      tbl_we = 1'b0; cnt_we = 1'b0; start = 1'b0;
    end
  endtask

  task automatic t_reset;
    check(test_en == 6'b0, "R1 enables", int'(test_en), 0);
    check(!busy && !done && !err, "R1 flags", int'({busy, done, err}), 0);
    check(elapsed == 16'd0, "R1 elapsed", int'(elapsed), 0);
  endtask

  task automatic t_default(input string tag);
    run_sched(-1);
    check(busy0 == 1, {tag, " R2 busy at first cycle"}, busy0, 1);
    check(first_hi[2] == 0 && first_hi[3] == 0, {tag, " R2 session0 start"}, first_hi[2], 0);
    for (int i = 0; i < 6; i++) begin
      check(hi_cnt[i] == t_len[i], {tag, " R3 window length"}, hi_cnt[i], t_len[i]);
      check(rises[i] == 1, {tag, " R3 single window"}, rises[i], 1);
    end
    check(first_hi[1] == 10 && first_hi[4] == 10, {tag, " R4 session1 start"}, first_hi[1], 10);
    check(first_hi[0] == 20 && first_hi[5] == 20, {tag, " R4 session2 start"}, first_hi[0], 20);
    check(max_pwr <= 4, {tag, " R5 budget"}, max_pwr, 4);
    check(done_at == 120, {tag, " R6 done timing"}, done_at, 120);
    check(busy_at_done == 0, {tag, " R6 busy low at done"}, busy_at_done, 0);
    check(el_end == 120, {tag, " R7 elapsed"}, el_end, 120);
    check(err_at == -1, {tag, " R11 no error"}, err_at, -1);
    @(negedge clk);
    check(!done, {tag, " R6 single pulse"}, int'(done), 0);
  endtask

  task automatic t_busy_ignore;
    run_sched(3);
    check(done_at == 120, "R9 writes while busy ignored", done_at, 120);
    check(first_hi[1] == 10, "R9 entry1 unchanged", first_hi[1], 10);
    check(rises[2] == 1, "R9 start while busy ignored", rises[2], 1);
    check(err_at == -1, "R9 no error from ignored write", err_at, -1);
  endtask

  task automatic t_over_budget;
    write_entry(0, 6'b010011);
    write_count(1);
    run_sched(-1);
    check(err_at == 0, "R5 over budget error", err_at, 0);
    check(hi_cnt[0] + hi_cnt[1] + hi_cnt[4] == 0, "R5 nothing enabled", hi_cnt[0], 0);
    check(done_at == -1, "R5 no done", done_at, -1);
    check(el_end == 0, "R7 cleared on start", el_end, 0);
    repeat (3) @(negedge clk);
    check(err && !busy && test_en == 0, "R11 error held", int'(err), 1);
  endtask

  task automatic t_at_budget;
    write_entry(0, 6'b001101);
    write_count(9);
    run_sched(-1);
    check(err_at == -1, "R11 error cleared by start", err_at, -1);
    check(done_at == 100, "R5 equal to limit accepted", done_at, 100);
    check(hi_cnt[3] == 5 && hi_cnt[2] == 10 && hi_cnt[0] == 100,
          "R3 mixed lengths", hi_cnt[3], 5);
    check(el_end == 100, "R9 oversize count ignored", el_end, 100);
  endtask

  task automatic t_zero_count;
    write_count(0);
    run_sched(-1);
    check(done_at == 0, "R10 immediate done", done_at, 0);
    check(el_end == 0, "R10 elapsed zero", el_end, 0);
    check(hi_cnt[0] + hi_cnt[2] + hi_cnt[3] == 0, "R10 no enable", hi_cnt[0], 0);
  endtask

  task automatic t_missing_done;
    write_entry(0, 6'b001100);
    write_count(3);
    done_allow = 6'b110111;
    run_sched(-1);
    check(err_at == 5, "R8 error timing", err_at, 5);
    check(hi_cnt[2] == 5, "R8 enables dropped", hi_cnt[2], 5);
    check(done_at == -1, "R8 no done", done_at, -1);
    check(el_end == 5, "R8 elapsed at abort", el_end, 5);
    done_allow = 6'b111111;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default("base");
    t_busy_ignore();
    t_over_budget();
    t_at_budget();
    t_zero_count();
    t_missing_done();
    t_default("recover");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule